// File: doc/BRIEF.md
# Microcoded Single-Bus Accumulator Core

This block is a small processor core in which program and data share one word-addressed memory. Every instruction runs as a short series of micro-steps, one per clock. In each step a hard-wired control word does three things: it picks at most one source for a shared data bus, it names the registers that capture the bus, and it selects an ALU action. The datapath holds three working registers (A, B, I), an ALU operand latch, an ALU result register, a program counter, a current and a next instruction register, and an overflow flag.

The memory sits outside the core and reads combinationally. The core does not drive a separate address. Every memory access uses the low bits of the value the bus carried in the previous micro-step. To reach a location, a program therefore first places the address on the bus and reads or writes in the step after. Conditional control flow comes from a single instruction, the overflow jump. It also flips the meaning of the flag, so a pair of these jumps forms an unconditional branch. The core raises `halt` and freezes once its program counter leaves the memory range.

Top module: `mcpu_core`

## Requirements
- R1: In reset the program counter holds all ones, the current instruction is the idle code 8, overflow is clear and `halt` is low. The first memory read after reset is at address 0.
- R2: A memory read (`mem_rd`) or write (`mem_we`) uses as its address the bus value of the previous micro-step. Read and write never occur in the same step.
- R3: ADD (code 0) first clears overflow, then sets A to A+B modulo 2^16. Overflow is set exactly when the true sum exceeds 65535.
- R4: INC (code 7) clears overflow, then sets A to A+1 modulo 2^16. Overflow is set exactly when A was 65535.
- R5: LIT (code 2) loads the word after the opcode into B and resumes after that word. LOAD (code 3) sets B to memory[I]. STOR (code 4) writes B to memory[I].
- R6: SWAP (code 5) exchanges A and B. SWPI (code 6) exchanges B and I. Both go through the ALU latch.
- R7: JOTO (code 1) with overflow set at its dispatch loads the PC from B, clears overflow, and runs the word at the new PC without incrementing the PC first.
- R8: JOTO with overflow clear at its dispatch runs the next word and sets overflow.
- R9: Code 8 and every word value above 8 (including 9 to 12) clear overflow. They change no other register.
- R10: Every instruction other than a taken JOTO ends with the same fetch tail: increment the PC, drive the PC, read the next opcode, then return the step counter to 0 for the new opcode.
- R11: `halt` is high while the PC is at or above 256 and not all ones. Once high it stays high, and no further memory access occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address, taken from the previous step's bus |
| mem_rd | output | 1 | Memory drives the bus this step |
| mem_we | output | 1 | Write `mem_wdata` to `mem_addr` at the clock edge |
| mem_wdata | output | 16 | Write data (current bus value) |
| mem_rdata | input | 16 | Combinational read data at `mem_addr` |
| halt | output | 1 | PC has left the memory range; the core is frozen |

## Verification
The flag set of a not-taken overflow jump happens in the same step as the memory read that fetches the following word. The word fetched in that step decides whether the next jump of a pair is taken. The bench triggers this coincidence on every flag-recording path and on the loop back-edge of a Fibonacci program. It judges the result by which flag word is stored, by the sequence values landing at their computed addresses, and by the run reaching its halt. A second coincidence is a preset overflow flag meeting ADD's clear step. Some runs enter ADD and the idle codes with overflow already set, so the stored flag shows whether the clear won.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  localparam int STEP_W = 3;

  localparam logic [3:0] OPC_ADD  = 4'd0;
  localparam logic [3:0] OPC_JMPV = 4'd1;
  localparam logic [3:0] OPC_IMM  = 4'd2;
  localparam logic [3:0] OPC_LD   = 4'd3;
  localparam logic [3:0] OPC_ST   = 4'd4;
  localparam logic [3:0] OPC_XAB  = 4'd5;
  localparam logic [3:0] OPC_XBI  = 4'd6;
  localparam logic [3:0] OPC_INC  = 4'd7;
  localparam logic [3:0] OPC_IDLE = 4'd8;

  typedef enum logic [3:0] {
    SRC_NONE, SRC_PC, SRC_IR, SRC_MEM, SRC_A, SRC_B, SRC_I, SRC_LAT, SRC_ALU
  } src_e;

  typedef struct packed {
    src_e src;
    logic pc_inc;
    logic pc_wr;
    logic nir_wr;
    logic a_wr;
    logic b_wr;
    logic i_wr;
    logic lat_wr;
    logic mem_wr;
    logic alu_add;
    logic alu_inc;
    logic clr_ov;
    logic set_ov;
    logic dispatch;
  } ctl_t;

  function automatic ctl_t ctl_none();
    ctl_t c;
    c = '0;
    c.src = SRC_NONE;
    return c;
  endfunction

  // Shared closing sequence; rel counts steps from the start of the tail.
  function automatic ctl_t fetch_tail(logic [STEP_W-1:0] rel);
    ctl_t c;
    c = ctl_none();
    case (rel)
      3'd0: c.pc_inc = 1'b1;
      3'd1: c.src = SRC_PC;
      3'd2: begin c.src = SRC_MEM; c.nir_wr = 1'b1; end
      default: c.dispatch = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mcpu_ucode.sv
module mcpu_ucode
  import mcpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      ir,
  input  logic [STEP_W-1:0] step,
  input  logic              jtaken,
  output ctl_t              ctl
);

  logic              is_idle;
  logic [2:0]        op;
  logic [STEP_W-1:0] tail_at;
  logic [STEP_W-1:0] rel;
  ctl_t              body;

  assign is_idle = (ir > W'(OPC_INC));
  assign op      = ir[2:0];
  assign rel     = step - tail_at;

  always_comb begin
    body    = ctl_none();
    tail_at = '0;
    if (!is_idle) begin
      case (op)
        OPC_ADD[2:0]: begin
          tail_at = 3'd3;
          case (step)
            3'd0: begin body.src = SRC_A; body.lat_wr = 1'b1; body.clr_ov = 1'b1; end
            3'd1: begin body.src = SRC_B; body.alu_add = 1'b1; end
            3'd2: begin body.src = SRC_ALU; body.a_wr = 1'b1; end
            default: ;
          endcase
        end
        OPC_IMM[2:0]: begin
          tail_at = 3'd3;
          case (step)
            3'd0: body.pc_inc = 1'b1;
            3'd1: body.src = SRC_PC;
            3'd2: begin body.src = SRC_MEM; body.b_wr = 1'b1; end
            default: ;
          endcase
        end
        OPC_LD[2:0]: begin
          tail_at = 3'd2;
          case (step)
            3'd0: body.src = SRC_I;
            3'd1: begin body.src = SRC_MEM; body.b_wr = 1'b1; end
            default: ;
          endcase
        end
        OPC_ST[2:0]: begin
          tail_at = 3'd2;
          case (step)
            3'd0: body.src = SRC_I;
            3'd1: begin body.src = SRC_B; body.mem_wr = 1'b1; end
            default: ;
          endcase
        end
        OPC_XAB[2:0]: begin
          tail_at = 3'd3;
          case (step)
            3'd0: begin body.src = SRC_A; body.lat_wr = 1'b1; end
            3'd1: begin body.src = SRC_B; body.a_wr = 1'b1; end
            3'd2: begin body.src = SRC_LAT; body.b_wr = 1'b1; end
            default: ;
          endcase
        end
        OPC_XBI[2:0]: begin
          tail_at = 3'd3;
          case (step)
            3'd0: begin body.src = SRC_B; body.lat_wr = 1'b1; end
            3'd1: begin body.src = SRC_I; body.b_wr = 1'b1; end
            3'd2: begin body.src = SRC_LAT; body.i_wr = 1'b1; end
            default: ;
          endcase
        end
        OPC_INC[2:0]: begin
          tail_at = 3'd3;
          case (step)
            3'd0: begin body.src = SRC_A; body.lat_wr = 1'b1; body.clr_ov = 1'b1; end
            3'd1: body.alu_inc = 1'b1;
            3'd2: begin body.src = SRC_ALU; body.a_wr = 1'b1; end
            default: ;
          endcase
        end
        default: tail_at = '0;
      endcase
    end
  end

  always_comb begin
    if (step >= tail_at) ctl = fetch_tail(rel);
    else                 ctl = body;
    if (!is_idle && op == OPC_JMPV[2:0]) begin
      if (jtaken) begin
        if (step == 3'd0) begin
          ctl.pc_inc = 1'b0;
          ctl.src    = SRC_B;
          ctl.pc_wr  = 1'b1;
        end
        if (step == 3'd1) ctl.clr_ov = 1'b1;
      end else if (step == 3'd2) begin
        ctl.set_ov = 1'b1;
      end
    end
    if (is_idle && step == 3'd0) ctl.clr_ov = 1'b1;
  end

endmodule

// File: rtl/mcpu_seq.sv
module mcpu_seq
  import mcpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  ctl_t              ctl,
  input  logic [W-1:0]      bus,
  input  logic              ov,
  output logic [W-1:0]      ir_q,
  output logic [STEP_W-1:0] step_q,
  output logic              jtaken_q
);

  logic [W-1:0] nir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q     <= W'(OPC_IDLE);
      nir_q    <= W'(OPC_IDLE);
      step_q   <= '0;
      jtaken_q <= 1'b0;
    end else if (run) begin
      if (ctl.nir_wr) nir_q <= bus;
      if (ctl.dispatch) begin
        ir_q     <= nir_q;
        step_q   <= '0;
        jtaken_q <= ov;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mcpu_dpath.sv
module mcpu_dpath
  import mcpu_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  ctl_t          ctl,
  input  logic [W-1:0]  ir,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  bus,
  output logic [W-1:0]  pc_q,
  output logic [W-1:0]  b_q,
  output logic [W-1:0]  lat_q,
  output logic          ov_q,
  output logic [AW-1:0] addr_q
);

  logic [W-1:0] a_q;
  logic [W-1:0] i_q;
  logic [W-1:0] alu_q;
  logic [W-1:0] alu_in;
  logic [W:0]   sum;
  logic         alu_go;

  function automatic logic [W:0] add_wide(logic [W-1:0] x, logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  always_comb begin
    case (ctl.src)
      SRC_PC:  bus = pc_q;
      SRC_IR:  bus = ir;
      SRC_MEM: bus = mem_rdata;
      SRC_A:   bus = a_q;
      SRC_B:   bus = b_q;
      SRC_I:   bus = i_q;
      SRC_LAT: bus = lat_q;
      SRC_ALU: bus = alu_q;
      default: bus = '0;
    endcase
  end

  assign alu_in = ctl.alu_inc ? W'(1) : bus;
  assign sum    = add_wide(lat_q, alu_in);
  assign alu_go = ctl.alu_add | ctl.alu_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '1;
      a_q    <= '0;
      b_q    <= '0;
      i_q    <= '0;
      lat_q  <= '0;
      alu_q  <= '0;
      ov_q   <= 1'b0;
      addr_q <= '0;
    end else if (run) begin
      addr_q <= bus[AW-1:0];
      if (ctl.pc_wr)       pc_q <= bus;
      else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
      if (ctl.a_wr)   a_q   <= bus;
      if (ctl.b_wr)   b_q   <= bus;
      if (ctl.i_wr)   i_q   <= bus;
      if (ctl.lat_wr) lat_q <= bus;
      if (alu_go)     alu_q <= sum[W-1:0];
      if (ctl.clr_ov)                ov_q <= 1'b0;
      else if (ctl.set_ov)           ov_q <= 1'b1;
      else if (alu_go && sum[W])     ov_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic                     mem_rd,
  output logic                     mem_we,
  output logic [W-1:0]             mem_wdata,
  input  logic [W-1:0]             mem_rdata,
  output logic                     halt
);

  localparam int AW = $clog2(DEPTH);

  ctl_t              ctl;
  logic [W-1:0]      bus;
  logic [W-1:0]      ir_q;
  logic [STEP_W-1:0] step_q;
  logic              jtaken_q;
  logic [W-1:0]      pc_q;
  logic [W-1:0]      b_q;
  logic [W-1:0]      lat_q;
  logic              ov_q;
  logic [AW-1:0]     addr_q;
  logic              run;
  logic              dispatch;

  assign halt     = (pc_q != '1) && (pc_q >= W'(DEPTH));
  assign run      = !halt;
  assign dispatch = ctl.dispatch;

  mcpu_ucode #(.W(W)) u_ucode (
    .ir(ir_q), .step(step_q), .jtaken(jtaken_q), .ctl(ctl)
  );

  mcpu_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .run(run), .ctl(ctl), .bus(bus), .ov(ov_q),
    .ir_q(ir_q), .step_q(step_q), .jtaken_q(jtaken_q)
  );

  mcpu_dpath #(.W(W), .AW(AW)) u_dpath (
    .clk(clk), .rst(rst), .run(run), .ctl(ctl), .ir(ir_q),
    .mem_rdata(mem_rdata), .bus(bus), .pc_q(pc_q), .b_q(b_q),
    .lat_q(lat_q), .ov_q(ov_q), .addr_q(addr_q)
  );

  assign mem_addr  = addr_q;
  assign mem_rd    = run && (ctl.src == SRC_MEM);
  assign mem_we    = run && ctl.mem_wr;
  assign mem_wdata = bus;

endmodule

// File: rtl/mcpu_checker.sv
module mcpu_checker
  import mcpu_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              halt,
  input logic              mem_rd,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [W-1:0]      bus,
  input logic [W-1:0]      ir_q,
  input logic [STEP_W-1:0] step_q,
  input logic              jtaken_q,
  input logic [W-1:0]      pc_q,
  input logic [W-1:0]      b_q,
  input logic [W-1:0]      lat_q,
  input logic              ov_q,
  input logic              dispatch
);

  p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we));

  p_addr_prev_bus_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_we) |-> mem_addr == $past(bus[AW-1:0]));

  p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (run && ir_q == W'(OPC_ADD) && step_q == 3'd2)
      |-> bus == W'($past(lat_q) + $past(b_q)));

  p_add_ov_r3: assert property (@(posedge clk) disable iff (rst)
    (run && ir_q == W'(OPC_ADD) && step_q == 3'd2)
      |-> ov_q == (W'($past(lat_q) + $past(b_q)) < $past(lat_q)));

  p_inc_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (run && ir_q == W'(OPC_INC) && step_q == 3'd2)
      |-> (bus == W'($past(lat_q) + 1'b1)) && (ov_q == ($past(lat_q) == {W{1'b1}})));

  p_jump_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (run && ir_q == W'(OPC_JMPV) && jtaken_q && step_q == 3'd1)
      |-> pc_q == $past(b_q));

  p_jump_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (run && ir_q == W'(OPC_JMPV) && jtaken_q && step_q == 3'd2) |-> !ov_q);

  p_skip_set_r8: assert property (@(posedge clk) disable iff (rst)
    (run && ir_q == W'(OPC_JMPV) && !jtaken_q && step_q == 3'd3) |-> ov_q);

  p_idle_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (run && ir_q > W'(OPC_INC) && step_q == 3'd1) |-> !ov_q);

  p_dispatch_r10: assert property (@(posedge clk) disable iff (rst)
    (run && dispatch) |=> step_q == '0);

  p_step_bound_r10: assert property (@(posedge clk) disable iff (rst)
    step_q <= 3'd6);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halt |-> !mem_rd && !mem_we);

endmodule

bind mcpu_core mcpu_checker #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .halt(halt), .mem_rd(mem_rd),
  .mem_we(mem_we), .mem_addr(mem_addr), .bus(bus), .ir_q(ir_q),
  .step_q(step_q), .jtaken_q(jtaken_q), .pc_q(pc_q), .b_q(b_q),
  .lat_q(lat_q), .ov_q(ov_q), .dispatch(dispatch)
);

// File: tb/mcpu_core_bench.sv
module mcpu_core_bench;

  localparam int ADD = 0, JOTO = 1, LIT = 2, LOAD = 3, STOR = 4;
  localparam int SWAP = 5, SWPI = 6, INC = 7, NOP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_we, halt;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [256];

  int checks = 0;
  int fails  = 0;
  logic        seen_rd = 1'b0;
  logic [7:0]  first_rd = 8'hFF;
  int          wr_count = 0;

  always #10 clk = ~clk;

  mcpu_core u_mcpu_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halt(halt)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && mem_rd && !seen_rd) begin
      first_rd = mem_addr;
      seen_rd  = 1'b1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(int a, int v);
    mem[a] = v[15:0];
  endtask

  task automatic begin_load();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 256; k++) mem[k] = '0;
    seen_rd = 1'b0;
  endtask

  task automatic go(string req);
    int n;
    rst = 1'b0;
    n = 0;
    while (!halt && n < 8000) begin
      @(negedge clk);
      n++;
    end
    chk(req, int'(halt), 1);
  endtask

  // Arithmetic probe: result word at 200, flag word (1 = overflow) at 201.
  task automatic arith(int pre, int op, int x, int y);
    begin_load();
    put(0, LIT); put(1, 2); put(2, pre);
    put(3, LIT); put(4, 200); put(5, SWPI);
    put(6, LIT); put(7, x); put(8, SWAP);
    put(9, LIT); put(10, y); put(11, op);
    put(12, SWAP); put(13, STOR);
    put(14, LIT); put(15, 201); put(16, SWPI);
    put(17, LIT); put(18, 40); put(19, JOTO);
    put(20, LIT); put(21, 0); put(22, STOR);
    put(23, LIT); put(24, 999); put(25, JOTO);
    put(40, LIT); put(41, 1); put(42, STOR);
    put(43, LIT); put(44, 999); put(45, JOTO); put(46, JOTO);
    go("R11 arith run halts");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected halt");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] vals [8];
    int f0, f1, f2;
    int w0;
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
             16'h8000, 16'hFFFE, 16'hFFFF, 16'h1234};

    // R1: reset state
    begin_load();
    chk("R1 halt low in reset", int'(halt), 0);
    chk("R1 no write in reset", int'(mem_we), 0);
    chk("R1 no read in reset", int'(mem_rd), 0);

    // R3: ADD sweep, half the runs with overflow preset
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        int s;
        s = int'(vals[i]) + int'(vals[j]);
        arith(((i + j) % 2 == 1) ? JOTO : NOP, ADD, vals[i], vals[j]);
        chk("R3 ADD sum", int'(mem[200]), s % 65536);
        chk("R3 ADD overflow flag", int'(mem[201]), (s > 65535) ? 1 : 0);
        if (i == 0 && j == 0) chk("R1 first read address", int'(first_rd), 0);
      end
    end

    // R4: INC sweep with overflow preset
    for (int i = 0; i < 8; i++) begin
      arith(JOTO, INC, vals[i], 16'h5555);
      chk("R4 INC sum", int'(mem[200]), (int'(vals[i]) + 1) % 65536);
      chk("R4 INC overflow flag", int'(mem[201]), (vals[i] == 16'hFFFF) ? 1 : 0);
    end

    // R9: idle code and codes above 8 with overflow preset
    for (int c = 8; c < 16; c++) begin
      arith(JOTO, c, 16'h0ABC + c, 16'h7777);
      chk("R9 idle keeps A", int'(mem[200]), 16'h0ABC + c);
      chk("R9 idle clears overflow", int'(mem[201]), 0);
    end

    // Fibonacci: F(k) at 99+k until the sum wraps, loop exit marker at 150
    begin_load();
    put(0, LIT); put(1, 100); put(2, SWPI); put(3, LIT); put(4, 1); put(5, STOR);
    put(6, LOAD); put(7, ADD); put(8, LIT); put(9, 40); put(10, JOTO);
    put(11, LOAD); put(12, SWAP); put(13, SWPI); put(14, SWAP); put(15, INC);
    put(16, SWAP); put(17, SWPI); put(18, STOR);
    put(19, LIT); put(20, 6); put(21, JOTO); put(22, JOTO);
    put(40, LIT); put(41, 150); put(42, SWPI); put(43, STOR);
    put(44, LIT); put(45, 999); put(46, JOTO); put(47, JOTO);
    go("R7 fib loop exits on overflow");
    f0 = 0; f1 = 1;
    for (int k = 2; k <= 24; k++) begin
      f2 = f0 + f1;
      chk("R5 R6 R10 fib value", int'(mem[99 + k]), f2);
      f0 = f1; f1 = f2;
    end
    chk("R2 wrapped sum not stored", int'(mem[124]), 0);
    chk("R8 exit marker pointer", int'(mem[150]), 123);

    // R11: frozen after halt
    w0 = wr_count;
    repeat (20) @(negedge clk);
    chk("R11 halt stays high", int'(halt), 1);
    chk("R11 no writes after halt", wr_count - w0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule